// File: doc/BRIEF.md
# Load/Store Bus Master Adapter

This block sits between the memory stage of a small RISC-V core and a simple valid/ready internal bus. The core hands it one decoded load or store at a time: a one-hot load kind, a one-hot store kind, a byte address, the register value to store and the destination register index. The adapter captures the request and presents it on the bus as a held transfer. For stores it computes the byte-lane write strobes and places the data on the matching lanes. For loads it picks the addressed byte or halfword out of the returned word and sign- or zero-extends it.

The slave answers on a two-bit response: bit 0 means the slave has finished the transfer, and bit 1 flags a bus error. The adapter keeps every bus output steady for as many wait cycles as the slave needs. When the transfer ends it pulses a completion strobe so a stalled pipeline can move on. A finished load returns a write-back enable, the register index and the extended data. An errored transfer raises an error pulse instead of a write-back.

Top module: `ls_bus_master`

## Requirements
- R1: After reset, busValid, busOp, busRd, wbEn, doneP and errP are low, busWe is 0000 and reqReady is high.
- R2: A request is taken on a clock edge where reqReady and reqValid are high and exactly one of the load kind and store kind is non-zero. From the next cycle busValid is high with busAddr equal to the request address, and busOp is high in that first bus cycle only.
- R3: The store kind bits are bit 0 byte, bit 1 halfword and bit 2 word. busWe is 0001, 0010, 0100 or 1000 for a byte store at address offset 0, 1, 2 or 3. It is 0011 or 1100 for a halfword at offset 0 or 2, and 1111 for a word. For a load, busWe is 0000 and busRd is high.
- R4: Store data is replicated so that the stored byte appears on all four lanes, the stored halfword on both halves, and a word passes unchanged.
- R5: The load kind bits are bit 0 signed byte, bit 1 unsigned byte, bit 2 signed halfword, bit 3 unsigned halfword and bit 4 word. A byte load at offset n returns busRdata bits [8n+7:8n]. A halfword load at offset 0 returns bits [15:0] and at offset 2 returns bits [31:16]. The value is sign-extended for the signed kinds and zero-extended for the unsigned ones. A word load returns all 32 bits.
- R6: While busResp bit 0 is low, busValid, busAddr, busWe, busWdata and busRd stay unchanged, and a response of 10 alone does not end the transfer.
- R7: In the cycle after one with busValid and busResp bit 0 high, doneP is high for exactly one cycle and busValid is low. For a load without error, wbEn is high with wbIdx and wbData for that load.
- R8: If busResp is 11 when the transfer ends, errP pulses with doneP and wbEn stays low.
- R9: While a transfer is outstanding, reqReady is low and a request presented on reqValid starts no transfer and does not change the bus outputs.
- R10: A request whose load kind and store kind are both zero is ignored: no bus transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqLoadKind | input | 5 | One-hot load kind |
| reqStoreKind | input | 3 | One-hot store kind |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Register value to store |
| reqRd | input | 5 | Destination register index |
| reqReady | output | 1 | Adapter idle, may accept |
| busAddr | output | 32 | Bus address |
| busWdata | output | 32 | Lane-placed write data |
| busValid | output | 1 | Transfer in progress |
| busWe | output | 4 | Byte-lane write strobes |
| busRd | output | 1 | Read strobe |
| busOp | output | 1 | One-cycle pulse at transfer start |
| busRdata | input | 32 | Read data from slave |
| busResp | input | 2 | Bit 0 slave ready, bit 1 bus error |
| wbEn | output | 1 | Register write-back enable |
| wbIdx | output | 5 | Write-back register index |
| wbData | output | 32 | Extended load data |
| doneP | output | 1 | Completion pulse |
| errP | output | 1 | Bus error pulse |

## Verification
The hardest case to reach from the ports is a long wait in which the slave raises only the error bit and the core meanwhile presents a fresh request. The adapter must treat neither event as an end or a new start. The stimulus holds the transfer open for several cycles. It drives response 10 in the first wait cycle and keeps a different request valid throughout. Every wait cycle it checks that the bus outputs are unchanged and that reqReady stays low. It then checks that no second transfer appears after completion.

// File: rtl/lsbm_pkg.sv
package lsbm_pkg;
  localparam int LD_KINDS = 5;
  localparam int ST_KINDS = 3;

  // control strobes handed from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // request taken this edge
    logic finish;   // slave answered this edge
    logic fault;    // slave answered with error this edge
  } lsbmCtl_t;
endpackage

// File: rtl/lsbm_ctrl.sv
module lsbm_ctrl
  import lsbm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqIsLoad,
  input  logic       reqIsStore,
  input  logic [1:0] busResp,
  output lsbmCtl_t   ctl,
  output logic       reqReady,
  output logic       busValid,
  output logic       busOp,
  output logic       busRd,
  output logic       wbEn,
  output logic       doneP,
  output logic       errP
);
  typedef enum logic { ST_IDLE, ST_WAIT } seqState_t;

  seqState_t state;
  logic      pendLoad;
  logic      opQ;

  always_comb begin
    ctl.capture = (state == ST_IDLE) && reqValid && (reqIsLoad != reqIsStore);
    ctl.finish  = (state == ST_WAIT) && busResp[0];
    ctl.fault   = ctl.finish && busResp[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendLoad <= 1'b0;
      opQ      <= 1'b0;
      wbEn     <= 1'b0;
      doneP    <= 1'b0;
      errP     <= 1'b0;
    end else begin
      opQ   <= ctl.capture;
      doneP <= ctl.finish;
      errP  <= ctl.fault;
      wbEn  <= ctl.finish && pendLoad && !busResp[1];
      if (ctl.capture) begin
        state    <= ST_WAIT;
        pendLoad <= reqIsLoad;
      end else if (ctl.finish) begin
        state <= ST_IDLE;
      end
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign busValid = (state == ST_WAIT);
  assign busOp    = opQ;
  assign busRd    = busValid && pendLoad;
endmodule

// File: rtl/lsbm_dpath.sv
module lsbm_dpath
  import lsbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 32,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  lsbmCtl_t            ctl,
  input  logic [LD_KINDS-1:0] reqLoadKind,
  input  logic [ST_KINDS-1:0] reqStoreKind,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [XLEN-1:0]     reqWdata,
  input  logic [IDX_W-1:0]    reqRd,
  input  logic [XLEN-1:0]     busRdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [XLEN-1:0]     busWdata,
  output logic [XLEN/8-1:0]   weHeld,
  output logic [IDX_W-1:0]    wbIdx,
  output logic [XLEN-1:0]     wbData
);
  localparam int LANES = XLEN / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int HALF  = XLEN / 2;

  logic [ADDR_W-1:0]   addrQ;
  logic [XLEN-1:0]     wdataQ;
  logic [LANES-1:0]    weQ;
  logic [IDX_W-1:0]    rdQ;
  logic [LD_KINDS-1:0] ldQ;
  logic [XLEN-1:0]     wbDataQ;

  logic [LANES-1:0]    strobeNext;
  logic [XLEN-1:0]     placedNext;
  logic [OFF_W-1:0]    reqOff;

  assign reqOff = reqAddr[OFF_W-1:0];

  // lane strobes and lane placement for the incoming store
  always_comb begin
    strobeNext = '0;
    placedNext = reqWdata;
    if (reqStoreKind[0]) begin
      strobeNext = LANES'(1) << reqOff;
      placedNext = {LANES{reqWdata[7:0]}};
    end else if (reqStoreKind[1]) begin
      strobeNext = reqOff[OFF_W-1] ? {2'b11, 2'b00} : {2'b00, 2'b11};
      placedNext = {2{reqWdata[15:0]}};
    end else if (reqStoreKind[2]) begin
      strobeNext = '1;
    end
  end

  // byte lanes of the returned word
  logic [7:0] laneByte [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneByte[g] = busRdata[8*g +: 8];
  end

  logic [7:0]      pickByte;
  logic [HALF-1:0] pickHalf;
  logic [XLEN-1:0] loadExt;

  assign pickByte = laneByte[addrQ[OFF_W-1:0]];
  assign pickHalf = addrQ[OFF_W-1] ? busRdata[XLEN-1:HALF] : busRdata[HALF-1:0];

  always_comb begin
    loadExt = busRdata;
    unique case (1'b1)
      ldQ[0]:  loadExt = {{(XLEN-8){pickByte[7]}}, pickByte};
      ldQ[1]:  loadExt = {{(XLEN-8){1'b0}}, pickByte};
      ldQ[2]:  loadExt = {{(XLEN-HALF){pickHalf[HALF-1]}}, pickHalf};
      ldQ[3]:  loadExt = {{(XLEN-HALF){1'b0}}, pickHalf};
      default: loadExt = busRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      weQ     <= '0;
      rdQ     <= '0;
      ldQ     <= '0;
      wbDataQ <= '0;
    end else begin
      if (ctl.capture) begin
        addrQ  <= reqAddr;
        wdataQ <= placedNext;
        weQ    <= strobeNext;
        rdQ    <= reqRd;
        ldQ    <= reqLoadKind;
      end
      if (ctl.finish && !ctl.fault) begin
        wbDataQ <= loadExt;
      end
    end
  end

  assign busAddr  = addrQ;
  assign busWdata = wdataQ;
  assign weHeld   = weQ;
  assign wbIdx    = rdQ;
  assign wbData   = wbDataQ;
endmodule

// File: rtl/ls_bus_master.sv
module ls_bus_master
  import lsbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 32,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [LD_KINDS-1:0] reqLoadKind,
  input  logic [ST_KINDS-1:0] reqStoreKind,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [XLEN-1:0]     reqWdata,
  input  logic [IDX_W-1:0]    reqRd,
  output logic                reqReady,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [XLEN-1:0]     busWdata,
  output logic                busValid,
  output logic [XLEN/8-1:0]   busWe,
  output logic                busRd,
  output logic                busOp,
  input  logic [XLEN-1:0]     busRdata,
  input  logic [1:0]          busResp,
  output logic                wbEn,
  output logic [IDX_W-1:0]    wbIdx,
  output logic [XLEN-1:0]     wbData,
  output logic                doneP,
  output logic                errP
);
  lsbmCtl_t          ctl;
  logic [XLEN/8-1:0] weHeld;

  lsbm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqIsLoad  (|reqLoadKind),
    .reqIsStore (|reqStoreKind),
    .busResp    (busResp),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .busValid   (busValid),
    .busOp      (busOp),
    .busRd      (busRd),
    .wbEn       (wbEn),
    .doneP      (doneP),
    .errP       (errP)
  );

  lsbm_dpath #(.ADDR_W(ADDR_W), .XLEN(XLEN), .IDX_W(IDX_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .reqLoadKind  (reqLoadKind),
    .reqStoreKind (reqStoreKind),
    .reqAddr      (reqAddr),
    .reqWdata     (reqWdata),
    .reqRd        (reqRd),
    .busRdata     (busRdata),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .weHeld       (weHeld),
    .wbIdx        (wbIdx),
    .wbData       (wbData)
  );

  assign busWe = busValid ? weHeld : '0;
endmodule

// File: rtl/ls_bus_master_chk.sv
module ls_bus_master_chk #(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              busValid,
  input logic              busOp,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [XLEN-1:0]   busWdata,
  input logic [XLEN/8-1:0] busWe,
  input logic [1:0]        busResp,
  input logic              wbEn,
  input logic              doneP,
  input logic              errP
);
  AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busResp[0] |=> busValid && $stable(busAddr) && $stable(busWe)
      && $stable(busWdata) && $stable(busRd)); // R6
  AST_OP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    busOp |=> !busOp); // R2
  AST_OP_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    busOp |-> busValid); // R2
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busResp[0] |=> doneP && !busValid); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP); // R7
  AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    errP |-> doneP && !wbEn); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !reqReady); // R9
  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> busWe == '0); // R3
endmodule

bind ls_bus_master ls_bus_master_chk #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .busValid (busValid),
  .busOp    (busOp),
  .busRd    (busRd),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busWe    (busWe),
  .busResp  (busResp),
  .wbEn     (wbEn),
  .doneP    (doneP),
  .errP     (errP)
);

// File: tb/tb_ls_bus_master.sv
module tb_ls_bus_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [4:0]  reqLoadKind = '0;
  logic [2:0]  reqStoreKind = '0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [4:0]  reqRd = '0;
  logic        reqReady;
  logic [31:0] busAddr, busWdata, busRdata = '0, wbData;
  logic        busValid, busRd, busOp, wbEn, doneP, errP;
  logic [3:0]  busWe;
  logic [1:0]  busResp = '0;
  logic [4:0]  wbIdx;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  ls_bus_master dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expStrobe(input logic [2:0] st, input logic [1:0] off);
    case (1'b1)
      st[0]:   return (off == 0) ? 4'b0001 : (off == 1) ? 4'b0010 : (off == 2) ? 4'b0100 : 4'b1000;
      st[1]:   return off[1] ? 4'b1100 : 4'b0011;
      st[2]:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] expPlaced(input logic [2:0] st, input logic [31:0] d);
    if (st[0]) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (st[1]) return {d[15:0], d[15:0]};
    return d;
  endfunction

  function automatic logic [31:0] expLoad(input logic [4:0] ld, input logic [1:0] off, input logic [31:0] r);
    logic [7:0]  b;
    logic [15:0] h;
    b = r >> (8 * off);
    h = off[1] ? r[31:16] : r[15:0];
    if (ld[0]) return {{24{b[7]}}, b};
    if (ld[1]) return {24'd0, b};
    if (ld[2]) return {{16{h[15]}}, h};
    if (ld[3]) return {16'd0, h};
    return r;
  endfunction

  // one full transfer; busy=1 keeps a rival request valid during the wait
  task automatic xfer(input logic [4:0] ld, input logic [2:0] st, input logic [31:0] a,
                      input logic [31:0] wd, input logic [4:0] rd, input logic [31:0] rdat,
                      input int waits, input logic [1:0] resp, input bit busy);
    @(negedge clk);
    reqValid = 1'b1; reqLoadKind = ld; reqStoreKind = st;
    reqAddr = a; reqWdata = wd; reqRd = rd;
    @(posedge clk); @(negedge clk);
    reqValid = busy; reqAddr = 32'hDEAD_0000; reqLoadKind = 5'b10000; reqStoreKind = '0;
    check("R2 valid", busValid, 1'b1);
    check("R2 op", busOp, 1'b1);
    check("R2 addr", busAddr, a);
    check("R3 strobe", busWe, expStrobe(st, a[1:0]));
    check("R3 rd", busRd, ld != 0);
    if (st != 0) check("R4 data", busWdata, expPlaced(st, wd));
    for (int w = 0; w < waits; w++) begin
      busResp = (w == 0) ? 2'b10 : 2'b00;
      @(posedge clk); @(negedge clk);
      check("R6 held valid", busValid, 1'b1);
      check("R6 held addr", busAddr, a);
      check("R6 held strobe", busWe, expStrobe(st, a[1:0]));
      check("R2 op once", busOp, 1'b0);
      check("R6 no done", doneP, 1'b0);
      if (busy) check("R9 not ready", reqReady, 1'b0);
    end
    busResp = resp; busRdata = rdat;
    @(posedge clk); @(negedge clk);
    busResp = 2'b00; reqValid = 1'b0;
    check("R7 done", doneP, 1'b1);
    check("R7 valid low", busValid, 1'b0);
    check("R8 err", errP, resp[1]);
    check("R8 wb", wbEn, (ld != 0) && !resp[1]);
    if (ld != 0 && !resp[1]) begin
      check("R5 data", wbData, expLoad(ld, a[1:0], rdat));
      check("R7 idx", wbIdx, rd);
    end
    @(posedge clk); @(negedge clk);
    check("R7 done once", doneP, 1'b0);
    check("R7 wb once", wbEn, 1'b0);
    if (busy) check("R9 no rival", busValid, 1'b0);
  endtask

  task automatic testReset();
    check("R1 valid", busValid, 1'b0);
    check("R1 op", busOp, 1'b0);
    check("R1 rd", busRd, 1'b0);
    check("R1 we", busWe, 4'b0000);
    check("R1 wb", {wbEn, doneP, errP}, 3'b000);
    check("R1 ready", reqReady, 1'b1);
  endtask

  task automatic testStores();
    for (int o = 0; o < 4; o++)
      xfer(5'b0, 3'b001, 32'h9000_0000 + o, 32'h1234_5678, 5'd0, 32'h0, o % 2, 2'b01, 1'b0);
    xfer(5'b0, 3'b010, 32'h9000_0000, 32'hAAAA_BEEF, 5'd0, 32'h0, 0, 2'b01, 1'b0);
    xfer(5'b0, 3'b010, 32'h9000_0002, 32'hAAAA_BEEF, 5'd0, 32'h0, 2, 2'b01, 1'b0);
    xfer(5'b0, 3'b100, 32'h9000_0004, 32'h1234_5678, 5'd0, 32'h0, 0, 2'b01, 1'b0);
  endtask

  task automatic testLoads();
    for (int o = 0; o < 4; o++) begin
      xfer(5'b00001, 3'b0, 32'h9000_0000 + o, 32'h0, 5'd3, 32'h80F1_7F82, 0, 2'b01, 1'b0);
      xfer(5'b00010, 3'b0, 32'h9000_0000 + o, 32'h0, 5'd4, 32'h80F1_7F82, 1, 2'b01, 1'b0);
    end
    xfer(5'b00100, 3'b0, 32'h9000_0002, 32'h0, 5'd5, 32'h8123_4567, 0, 2'b01, 1'b0);
    xfer(5'b01000, 3'b0, 32'h9000_0002, 32'h0, 5'd6, 32'h8123_4567, 0, 2'b01, 1'b0);
    xfer(5'b00100, 3'b0, 32'h9000_0000, 32'h0, 5'd7, 32'h1234_F678, 0, 2'b01, 1'b0);
    xfer(5'b10000, 3'b0, 32'h9000_0000, 32'h0, 5'd31, 32'h1234_5678, 3, 2'b01, 1'b0);
  endtask

  task automatic testBusyAndError();
    xfer(5'b10000, 3'b0, 32'h9000_0010, 32'h0, 5'd9, 32'hCAFE_F00D, 4, 2'b01, 1'b1);
    xfer(5'b10000, 3'b0, 32'h9000_0014, 32'h0, 5'd9, 32'hCAFE_F00D, 2, 2'b11, 1'b0);
    xfer(5'b0, 3'b100, 32'h9000_0018, 32'h5555_0000, 5'd0, 32'h0, 0, 2'b11, 1'b0);
  endtask

  task automatic testEmptyRequest();
    @(negedge clk);
    reqValid = 1'b1; reqLoadKind = '0; reqStoreKind = '0; reqAddr = 32'h9000_0020;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check("R10 no transfer", busValid, 1'b0);
    check("R10 ready", reqReady, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    testStores();
    testLoads();
    testBusyAndError();
    testEmptyRequest();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule